// File: doc/BRIEF.md
# Sense Path Control Register

This block holds the ten control bits that steer the head-temperature sensing path and the converter input selection. A host shifts a word in serially on a dedicated shift clock, most significant bit first. A hold stage then copies that word to the control outputs. The hold stage is open while its latch input is high, and while open it follows the shift register. When the latch input is low it keeps the last word it took. Tying the latch input high makes the outputs track each shifted bit.

The held word is decoded into several controls: a head selector, an offset code for the offset DAC together with the offset it stands for in thirty-seconds of the reference, the converter channel code and a one-hot multiplexer select. A current-source enable is driven high only when the word's on bit and an external active-low enable pin agree. All three serial inputs are resynchronised to the system clock through a chain of configurable depth. Data and shift clock pass through the same number of stages, so their relative timing is kept.

Top module: `snsreg_top`

## Requirements
- R1: While `rst_n` is low, and after it, until a word is latched, every held bit is 0. So `head_b_o`=0, `isrc_on_o`=0, `dac_code_o`=0, `offset_32nds_o`=16, `chan_code_o`=0, `chan_onehot_o`=8'b0000_0001, `chan_internal_o`=1 and `chan_external_o`=0.
- R2: Each rising edge of `cfg_sclk` shifts `cfg_sdat` into bit 0 of the word, and the older bits move one place up. The field layout of the word is: bit 9 is the head select, bit 8 is the source on bit, bits 7..3 are the DAC code (bit 7 is the MSB) and bits 2..0 are the channel code.
- R3: While `cfg_latch` is low, shifting has no effect on any output.
- R4: While `cfg_latch` is high, the outputs follow the shift register after each shifted bit.
- R5: The word present when `cfg_latch` falls stays on the outputs through later shifting.
- R6: `isrc_on_o` is 1 exactly when the held on bit is 1 and `isrc_en_n_i` is 0.
- R7: `chan_onehot_o` has only bit `chan_code_o` set. `chan_internal_o` is 1 for code 0 only. `chan_external_o` is 1 for codes 1 to 5. Codes 6 and 7 assert neither of those two outputs.
- R8: `offset_32nds_o` equals 16 plus the DAC code, which gives 16 for code 0 and 47 for code 31.
- R9: `head_b_o` is the held bit 9: 0 selects the head A sense resistor and 1 selects head B.
- R10: If more than ten bits are shifted, only the last ten remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sclk | input | 1 | Serial shift clock, sampled |
| cfg_sdat | input | 1 | Serial data, MSB first |
| cfg_latch | input | 1 | Hold stage open while high |
| isrc_en_n_i | input | 1 | External active-low source enable |
| head_b_o | output | 1 | 0 selects head A, 1 selects head B |
| isrc_on_o | output | 1 | Current source enable |
| dac_code_o | output | 5 | Offset DAC code |
| offset_32nds_o | output | 6 | Offset in 1/32 of reference |
| chan_code_o | output | 3 | Converter channel code |
| chan_onehot_o | output | 8 | One-hot channel select |
| chan_internal_o | output | 1 | Internal head-voltage channel chosen |
| chan_external_o | output | 1 | One of the five external inputs chosen |

## Verification
The bench builds the block with its default field widths and the default synchroniser depth of two. This covers all eight channel codes and the DAC code extremes 0 and 31. The bench holds every serial level for four system clocks, which is enough for a bit to cross the synchroniser, the edge detector and the hold stage before the outputs are sampled. It also covers both latch modes, a word longer than ten bits, and a reset asserted in the middle of a run.

// File: rtl/snsreg_pkg.sv
package snsreg_pkg;
  localparam int DAC_W  = 5;
  localparam int CHAN_W = 3;
  localparam int WORD_W = 2 + DAC_W + CHAN_W;
  localparam int NUM_CH = 1 << CHAN_W;
  localparam int EXT_CH = 5;
  localparam int OFS_W  = DAC_W + 1;

  // field order is behaviour: bit WORD_W-1 is shifted in first
  typedef struct packed {
    logic              head_b;
    logic              src_on;
    logic [DAC_W-1:0]  dac;
    logic [CHAN_W-1:0] chan;
  } ctl_word_t;

  // offset = half reference + code/2^DAC_W, expressed in 2^DAC_W-ths
  function automatic logic [OFS_W-1:0] ofs_steps(input logic [DAC_W-1:0] code);
    return OFS_W'(1 << (DAC_W - 1)) + OFS_W'(code);
  endfunction

  function automatic logic src_agree(input logic on_bit, input logic pin_n);
    return on_bit & ~pin_n;
  endfunction
endpackage

// File: rtl/snsreg_sync.sv
module snsreg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
          chain[0] <= d;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/snsreg_shift.sv
module snsreg_shift
  import snsreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdat,
  output logic              shift_rise,
  output logic [WORD_W-1:0] word_q
);
  logic sclk_prev;

  assign shift_rise = sclk & ~sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      word_q    <= '0;
    end else begin
      sclk_prev <= sclk;
      if (shift_rise) word_q <= {word_q[WORD_W-2:0], sdat};
    end
  end
endmodule

// File: rtl/snsreg_hold.sv
module snsreg_hold
  import snsreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open,
  input  logic [WORD_W-1:0] word_d,
  output logic [WORD_W-1:0] held_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= '0;
    else if (open) held_q <= word_d;
  end
endmodule

// File: rtl/snsreg_decode.sv
module snsreg_decode
  import snsreg_pkg::*;
(
  input  logic              [WORD_W-1:0] held,
  input  logic                           pin_en_n,
  output logic                           head_b,
  output logic                           src_on,
  output logic              [DAC_W-1:0]  dac,
  output logic              [OFS_W-1:0]  ofs,
  output logic              [CHAN_W-1:0] chan,
  output logic              [NUM_CH-1:0] onehot,
  output logic                           ch_int,
  output logic                           ch_ext
);
  ctl_word_t w;
  assign w      = ctl_word_t'(held);
  assign head_b = w.head_b;
  assign src_on = src_agree(w.src_on, pin_en_n);
  assign dac    = w.dac;
  assign ofs    = ofs_steps(w.dac);
  assign chan   = w.chan;
  assign ch_int = (w.chan == '0);
  assign ch_ext = (w.chan != '0) && (int'(w.chan) <= EXT_CH);

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
      assign onehot[g] = (int'(w.chan) == g);
    end
  endgenerate
endmodule

// File: rtl/snsreg_top.sv
module snsreg_top
  import snsreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sclk,
  input  logic              cfg_sdat,
  input  logic              cfg_latch,
  input  logic              isrc_en_n_i,
  output logic              head_b_o,
  output logic              isrc_on_o,
  output logic [DAC_W-1:0]  dac_code_o,
  output logic [OFS_W-1:0]  offset_32nds_o,
  output logic [CHAN_W-1:0] chan_code_o,
  output logic [NUM_CH-1:0] chan_onehot_o,
  output logic              chan_internal_o,
  output logic              chan_external_o
);
  logic [2:0]        sync_q;
  logic              s_sclk;
  logic              s_sdat;
  logic              lat_open;
  logic              shift_rise;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] held_q;

  snsreg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cfg_latch, cfg_sdat, cfg_sclk}), .q(sync_q)
  );
  assign s_sclk   = sync_q[0];
  assign s_sdat   = sync_q[1];
  assign lat_open = sync_q[2];

  snsreg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(s_sclk), .sdat(s_sdat),
    .shift_rise(shift_rise), .word_q(word_q)
  );

  snsreg_hold u_hold (
    .clk(clk), .rst_n(rst_n), .open(lat_open),
    .word_d(word_q), .held_q(held_q)
  );

  snsreg_decode u_dec (
    .held(held_q), .pin_en_n(isrc_en_n_i),
    .head_b(head_b_o), .src_on(isrc_on_o), .dac(dac_code_o),
    .ofs(offset_32nds_o), .chan(chan_code_o), .onehot(chan_onehot_o),
    .ch_int(chan_internal_o), .ch_ext(chan_external_o)
  );
endmodule

// File: rtl/snsreg_chk.sv
module snsreg_chk
  import snsreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              shift_rise,
  input logic              s_sdat,
  input logic              lat_open,
  input logic [WORD_W-1:0] word_q,
  input logic [WORD_W-1:0] held_q,
  input logic              isrc_en_n_i,
  input logic              isrc_on_o,
  input logic [NUM_CH-1:0] chan_onehot_o
);
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise |=> word_q == $past({word_q[WORD_W-2:0], s_sdat}));

  a_r3_closed_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_open |=> $stable(held_q));

  a_r4_open_follow: assert property (@(posedge clk) disable iff (!rst_n)
    lat_open |=> held_q == $past(word_q));

  a_r6_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
    isrc_on_o |-> !isrc_en_n_i);

  a_r6_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    isrc_on_o |-> held_q[WORD_W-2]);

  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chan_onehot_o) == 1);
endmodule

bind snsreg_top snsreg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shift_rise(shift_rise), .s_sdat(s_sdat),
  .lat_open(lat_open), .word_q(word_q), .held_q(held_q),
  .isrc_en_n_i(isrc_en_n_i), .isrc_on_o(isrc_on_o),
  .chan_onehot_o(chan_onehot_o)
);

// File: tb/snsreg_top_test.sv
module snsreg_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sclk = 1'b0, cfg_sdat = 1'b0, cfg_latch = 1'b0, isrc_en_n_i = 1'b0;
  logic head_b_o, isrc_on_o, chan_internal_o, chan_external_o;
  logic [4:0] dac_code_o;
  logic [5:0] offset_32nds_o;
  logic [2:0] chan_code_o;
  logic [7:0] chan_onehot_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [9:0] sent_sr = '0;
  logic [9:0] exp_q [$];

  always #4 clk = ~clk;

  snsreg_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_sclk(cfg_sclk), .cfg_sdat(cfg_sdat),
    .cfg_latch(cfg_latch), .isrc_en_n_i(isrc_en_n_i), .head_b_o(head_b_o),
    .isrc_on_o(isrc_on_o), .dac_code_o(dac_code_o),
    .offset_32nds_o(offset_32nds_o), .chan_code_o(chan_code_o),
    .chan_onehot_o(chan_onehot_o), .chan_internal_o(chan_internal_o),
    .chan_external_o(chan_external_o)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    cfg_sdat = b;
    cfg_sclk = 1'b0;
    wait_n(4);
    cfg_sclk = 1'b1;
    wait_n(4);
    sent_sr = {sent_sr[8:0], b};
  endtask

  task automatic send_word(input logic [15:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
    cfg_sclk = 1'b0;
    wait_n(4);
  endtask

  task automatic strobe;
    cfg_latch = 1'b1;
    wait_n(4);
    cfg_latch = 1'b0;
    wait_n(6);
  endtask

  task automatic expect_word(input logic [9:0] w);
    exp_q.push_back(w);
  endtask

  // monitor side: pop one expected word and compare every output
  task automatic check_out(input string req);
    logic [9:0]  w;
    logic [25:0] act, exv;
    logic [7:0]  oh;
    w = exp_q.pop_front();
    oh = 8'b1 << w[2:0];
    exv = {w[9], (w[8] && !isrc_en_n_i), w[7:3], 6'd16 + {1'b0, w[7:3]},
           w[2:0], oh, (w[2:0] == 3'd0), (w[2:0] >= 3'd1 && w[2:0] <= 3'd5)};
    act = {head_b_o, isrc_on_o, dac_code_o, offset_32nds_o, chan_code_o,
           chan_onehot_o, chan_internal_o, chan_external_o};
    total++;
    if (act !== exv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (word %b)", req, act, exv, w);
    end
  endtask

  initial begin
    wait_n(3);
    // R1: values during reset
    expect_word(10'd0); check_out("R1 in reset");
    rst_n = 1'b1;
    wait_n(3);
    expect_word(10'd0); check_out("R1 after reset");

    // R2 R9 R8 R6: full word, source enabled by pin
    send_word(16'b11_10110_011, 10); strobe;
    expect_word(10'b11_10110_011); check_out("R2 R9 R8 R6 load");
    isrc_en_n_i = 1'b1; wait_n(1);
    expect_word(10'b11_10110_011); check_out("R6 pin high blocks source");
    isrc_en_n_i = 1'b0; wait_n(1);

    // R3: shifting with latch low leaves outputs unchanged
    send_word(16'b00_00101_110, 10);
    expect_word(10'b11_10110_011); check_out("R3 closed latch ignores shift");
    strobe;
    expect_word(10'b00_00101_110); check_out("R5 strobe takes new word");
    // R6: on bit 0 keeps source off with pin low
    expect_word(10'b00_00101_110); check_out("R6 bit low blocks source");

    // R5: after latch falls, later bits do not reach outputs
    send_word(16'b101, 3);
    expect_word(10'b00_00101_110); check_out("R5 held after fall");

    // R7: every channel code, R9 both heads
    for (int c = 0; c < 8; c++) begin
      logic [9:0] w;
      w = {c[0], 1'b1, 5'(c * 3 + 1), 3'(c)};
      send_word({6'd0, w}, 10); strobe;
      expect_word(w); check_out("R7 channel decode");
    end

    // R8: DAC code extremes
    send_word(16'b01_00000_101, 10); strobe;
    expect_word(10'b01_00000_101); check_out("R8 code 0");
    send_word(16'b01_11111_100, 10); strobe;
    expect_word(10'b01_11111_100); check_out("R8 code 31");

    // R10: 13 bits shifted, last ten kept
    send_word(16'b101_10_01101_010, 13); strobe;
    expect_word(10'b10_01101_010); check_out("R10 overlong word");

    // R4: transparent, outputs follow every bit
    cfg_latch = 1'b1;
    wait_n(4);
    for (int i = 9; i >= 0; i--) begin
      logic [9:0] pat;
      pat = 10'b01_10011_001;
      send_bit(pat[i]);
      wait_n(2);
      expect_word(sent_sr); check_out("R4 transparent follow");
    end
    cfg_latch = 1'b0;
    wait_n(6);

    // R1: reset in the middle of a run
    rst_n = 1'b0; sent_sr = '0;
    wait_n(2);
    expect_word(10'd0); check_out("R1 mid-run reset");
    rst_n = 1'b1;
    wait_n(2);
    expect_word(10'd0); check_out("R1 released");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule